// File: doc/BRIEF.md
# Programmable Chip-Select Strobe Port

This block is a four-pin port for a small microcontroller bus. Software picks the role of each pin on its own. A pin can be a plain quasi-bidirectional I/O bit, driven from a port latch. It can also be an active-low chip-select strobe. In strobe mode the pin goes low while the external bus is doing a read, a write, or either one, and the bus address falls inside that pin's programmed window. This lets a peripheral be selected with no external glue logic.

Software sets up the port through a byte-wide register interface. Each pin has a 16-bit base address, stored as two bytes. Two control bytes hold the mode and the window size for each pin, and one register holds the port latch. The strobe path has no register in it: a pin follows the bus address and strobes within the same cycle. Configuration writes take effect at the clock edge that accepts them.

Top module: `strobe_port`

## Requirements
- R1: During and after synchronous reset (rst_n low at a clock edge), every base address and control byte is 0 and the port latch is all ones. All pins are then in mode 0 with pin_out = 1 and pin_oe = 0.
- R2: Register map for writes (reg_we high at a clock edge) and combinational reads on reg_rdata:
  - Base address of pin n: low byte at address 2n, high byte at address 2n+1.
  - Control byte at 8 covers pins 0 and 1; control byte at 9 covers pins 2 and 3. In each control byte, the even pin's mode is in bits [1:0] and its window code in bits [3:2]; the odd pin's mode is in bits [5:4] and its window code in bits [7:6].
  - Address 10: a write sets the port latch from wdata[3:0]; a read returns pin_in in bits [3:0].
  - Address 11: a read returns the latch in bits [3:0].
  - Addresses 12 to 15 read as 0, and writes to them change nothing.
- R3: In mode 0, a pin drives pin_out = its latch bit and pin_oe = inverse of that bit (strong low, released high).
- R4: In mode 1, pin_oe = 1, and pin_out is 0 exactly when bus_rd_n is 0 and the address matches.
- R5: In mode 2, pin_oe = 1, and pin_out is 0 exactly when bus_wr_n is 0 and the address matches.
- R6: In mode 3, pin_oe = 1, and pin_out is 0 when either bus_rd_n or bus_wr_n is 0 and the address matches.
- R7: With window code w (0 to 3), the address matches when bus_addr and the base agree after both are shifted right by w bits. This gives windows of 1, 2, 4 or 8 bytes.
- R8: A strobe follows bus_addr, bus_rd_n and bus_wr_n within the same cycle, with no clock edge in between.
- R9: Pins decode independently. Where windows overlap, every matching pin asserts.
- R10: A register write changes pin behaviour only from the clock edge that accepts it. Before that edge, the old setting still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_addr | input | 16 | External bus address |
| bus_rd_n | input | 1 | External bus read strobe, active low |
| bus_wr_n | input | 1 | External bus write strobe, active low |
| pin_in | input | 4 | Pin levels seen from the pads |
| pin_out | output | 4 | Pin output values |
| pin_oe | output | 4 | Pin output enables |

## Verification
Two things can happen in the same cycle: a register write that reconfigures a pin, and a live bus access that hits that pin. The bench starts a read on a strobe pin's base address. In that same cycle it writes the control byte that returns the pin to mode 0. It samples the pin once before the accepting edge, where the old strobe must still show, and once after it, where the latch level must appear. Around these cases, an exhaustive sweep of all modes, windows, strobe combinations and overlapping bases is compared against an arithmetic model.

// File: rtl/strobe_port_pkg.sv
`timescale 1ns/1ps
// Shared types for the strobe port: pin role encoding and per-pin setting.
package strobe_port_pkg;
    typedef enum logic [1:0] {
        PM_GPIO = 2'd0,
        PM_RD   = 2'd1,
        PM_WR   = 2'd2,
        PM_RDWR = 2'd3
    } pin_mode_e;

    // Setting of one pin, laid out exactly as its nibble in a control byte.
    typedef struct packed {
        logic [1:0] span;
        pin_mode_e  mode;
    } pin_cfg_t;
endpackage

// File: rtl/strobe_port_regs.sv
`timescale 1ns/1ps
// Register file of the strobe port.
// It holds the base addresses, the control bytes and the port latch, and it
// serves combinational reads. It assumes AW == 2*DW, an even NPINS, and an
// address space large enough for 2*NPINS + NPINS/2 + 2 registers.
module strobe_port_regs
    import strobe_port_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int RAW   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [RAW-1:0]              reg_addr,
    input  logic [DW-1:0]               reg_wdata,
    output logic [DW-1:0]               reg_rdata,
    input  logic [NPINS-1:0]            pin_in,
    output logic [NPINS-1:0][AW-1:0]    base_o,
    output pin_cfg_t [NPINS-1:0]        cfg_o,
    output logic [NPINS-1:0]            latch_o
);
    localparam int NCTRL      = NPINS / 2;
    localparam int CTRL_BASE  = 2 * NPINS;
    localparam int LATCH_ADDR = CTRL_BASE + NCTRL;
    localparam int LREAD_ADDR = LATCH_ADDR + 1;
    localparam int CFGW       = $bits(pin_cfg_t);

    logic [NPINS-1:0][AW-1:0] base_q;
    logic [NCTRL-1:0][DW-1:0] ctrl_q;
    logic [NPINS-1:0]         latch_q;

    // Register writes; reset clears settings and sets the latch high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            ctrl_q  <= '0;
            latch_q <= '1;
        end else if (reg_we) begin
            for (int i = 0; i < NPINS; i++) begin
                if (reg_addr == RAW'(2 * i))     base_q[i][DW-1:0]  <= reg_wdata;
                if (reg_addr == RAW'(2 * i + 1)) base_q[i][AW-1:DW] <= reg_wdata;
            end
            for (int c = 0; c < NCTRL; c++) begin
                if (reg_addr == RAW'(CTRL_BASE + c)) ctrl_q[c] <= reg_wdata;
            end
            if (reg_addr == RAW'(LATCH_ADDR)) latch_q <= reg_wdata[NPINS-1:0];
        end
    end

    // Combinational read mux; unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (reg_addr == RAW'(2 * i))     reg_rdata = base_q[i][DW-1:0];
            if (reg_addr == RAW'(2 * i + 1)) reg_rdata = base_q[i][AW-1:DW];
        end
        for (int c = 0; c < NCTRL; c++) begin
            if (reg_addr == RAW'(CTRL_BASE + c)) reg_rdata = ctrl_q[c];
        end
        if (reg_addr == RAW'(LATCH_ADDR)) reg_rdata = {{(DW-NPINS){1'b0}}, pin_in};
        if (reg_addr == RAW'(LREAD_ADDR)) reg_rdata = {{(DW-NPINS){1'b0}}, latch_q};
    end

    // Each pin takes its nibble out of the shared control bytes.
    for (genvar g = 0; g < NPINS; g++) begin : g_cfg
        assign cfg_o[g] = pin_cfg_t'(ctrl_q[g/2][(g%2)*CFGW +: CFGW]);
    end

    assign base_o  = base_q;
    assign latch_o = latch_q;

    // R1: reset leaves every setting at its default.
    a_r1_reset_defaults: assert property (@(posedge clk)
        !rst_n |=> (latch_q == '1 && ctrl_q == '0 && base_q == '0));

    // R2: a latch write lands on the next edge.
    a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RAW'(LATCH_ADDR)) |=> latch_q == $past(reg_wdata[NPINS-1:0]));

    // R2: a write to an unmapped address leaves all state unchanged.
    a_r2_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr > RAW'(LATCH_ADDR)) |=>
        ($stable(base_q) && $stable(ctrl_q) && $stable(latch_q)));
endmodule

// File: rtl/strobe_port_decode.sv
`timescale 1ns/1ps
// Address and strobe decode for the strobe port.
// For every pin, it compares the bus address against the pin's base with the
// low `span` bits ignored, then qualifies the result with the bus strobe that
// the pin's mode selects. The path is purely combinational.
module strobe_port_decode
    import strobe_port_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int AW    = 16
) (
    input  logic [AW-1:0]            bus_addr,
    input  logic                     bus_rd_n,
    input  logic                     bus_wr_n,
    input  logic [NPINS-1:0][AW-1:0] base_i,
    input  pin_cfg_t [NPINS-1:0]     cfg_i,
    output logic [NPINS-1:0]         hit_o
);
    logic rd_act, wr_act;
    assign rd_act = ~bus_rd_n;
    assign wr_act = ~bus_wr_n;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic [AW-1:0] ign;
        logic          match;
        logic          qual;

        // Build the window mask and the address match for this pin.
        always_comb begin
            ign   = AW'((32'd1 << cfg_i[g].span) - 32'd1);
            match = ((bus_addr ^ base_i[g]) & ~ign) == '0;
        end

        // Choose the bus strobe(s) that qualify this pin.
        always_comb begin
            unique case (cfg_i[g].mode)
                PM_RD:   qual = rd_act;
                PM_WR:   qual = wr_act;
                PM_RDWR: qual = rd_act | wr_act;
                default: qual = 1'b0;
            endcase
        end

        assign hit_o[g] = match & qual;
    end
endmodule

// File: rtl/strobe_port_pinmux.sv
`timescale 1ns/1ps
// Output selection for the strobe port.
// A pin in mode 0 behaves as a quasi-bidirectional bit: it drives low
// strongly and releases for a high, relying on a pad pull-up. In any strobe
// mode, the pin drives the inverse of its decode hit.
module strobe_port_pinmux
    import strobe_port_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  pin_cfg_t [NPINS-1:0] cfg_i,
    input  logic [NPINS-1:0]     latch_i,
    input  logic [NPINS-1:0]     hit_i,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe
);
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        // Select the latch or the active-low strobe for this pin.
        always_comb begin
            if (cfg_i[g].mode == PM_GPIO) begin
                pin_out[g] = latch_i[g];
                pin_oe[g]  = ~latch_i[g];
            end else begin
                pin_out[g] = ~hit_i[g];
                pin_oe[g]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/strobe_port.sv
`timescale 1ns/1ps
// Top of the programmable chip-select strobe port.
// It joins the register file, the per-pin decode and the output mux. The
// strobe outputs are combinational from the bus inputs and the configuration
// registers, and it assumes the bus inputs are settled inside the cycle.
module strobe_port
    import strobe_port_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int RAW   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [RAW-1:0]   reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_rd_n,
    input  logic             bus_wr_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);
    localparam int MAXSPAN = 3;

    logic [NPINS-1:0][AW-1:0] base;
    pin_cfg_t [NPINS-1:0]     cfg;
    logic [NPINS-1:0]         latch;
    logic [NPINS-1:0]         hit;

    strobe_port_regs #(.NPINS(NPINS), .AW(AW), .DW(DW), .RAW(RAW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .base_o    (base),
        .cfg_o     (cfg),
        .latch_o   (latch)
    );

    strobe_port_decode #(.NPINS(NPINS), .AW(AW)) u_decode (
        .bus_addr (bus_addr),
        .bus_rd_n (bus_rd_n),
        .bus_wr_n (bus_wr_n),
        .base_i   (base),
        .cfg_i    (cfg),
        .hit_o    (hit)
    );

    strobe_port_pinmux #(.NPINS(NPINS)) u_pinmux (
        .cfg_i   (cfg),
        .latch_i (latch),
        .hit_i   (hit),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        // R3: a quasi-bidirectional pin never drives a high.
        a_r3_gpio_drive: assert property (@(posedge clk) disable iff (!rst_n)
            cfg[g].mode == PM_GPIO |-> pin_oe[g] != pin_out[g]);
        // R4: a read-strobe pin stays high without a bus read.
        a_r4_rd_only: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[g].mode == PM_RD && bus_rd_n) |-> (pin_out[g] && pin_oe[g]));
        // R5: a write-strobe pin stays high without a bus write.
        a_r5_wr_only: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[g].mode == PM_WR && bus_wr_n) |-> (pin_out[g] && pin_oe[g]));
        // R6: with the bus idle, no strobe pin is low.
        a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[g].mode != PM_GPIO && bus_rd_n && bus_wr_n) |-> pin_out[g]);
        // R7: an active strobe implies the address lies in the widest window.
        a_r7_hit_in_window: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[g].mode != PM_GPIO && !pin_out[g]) |->
            bus_addr[AW-1:MAXSPAN] == base[g][AW-1:MAXSPAN]);
    end
endmodule

// File: tb/strobe_port_bench.sv
`timescale 1ns/1ps
// Self-checking bench: exhaustive sweep of modes, windows and strobes
// against an arithmetic model, plus reset, map and same-cycle cases.
module strobe_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] bus_addr = '0;
    logic        bus_rd_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic [3:0]  pin_in = 4'hA;
    logic [3:0]  pin_out, pin_oe;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_base [4];
    logic [1:0]  m_mode [4];
    logic [1:0]  m_span [4];
    logic [3:0]  m_latch;

    always #2 clk = ~clk;

    strobe_port u_strobe_port (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input string tag);
        reg_addr = a;
        #0.5;
        check(reg_rdata == e, tag, {8'h0, reg_rdata}, {8'h0, e});
    endtask

    function automatic logic [7:0] ctrl_byte(input int pair);
        return {m_span[2*pair+1], m_mode[2*pair+1], m_span[2*pair], m_mode[2*pair]};
    endfunction

    task automatic set_pin(input int p, input logic [15:0] b, input logic [1:0] m, input logic [1:0] s);
        m_base[p] = b; m_mode[p] = m; m_span[p] = s;
        wr(4'(2*p), b[7:0]);
        wr(4'(2*p+1), b[15:8]);
        wr(4'(8 + p/2), ctrl_byte(p/2));
    endtask

    // Expected outputs from R3..R7 and R9.
    function automatic logic [7:0] expect_pins(input logic [15:0] a, input logic rn, input logic wn);
        logic [3:0] o, e;
        for (int p = 0; p < 4; p++) begin
            bit hit, m;
            m = (a >> m_span[p]) == (m_base[p] >> m_span[p]);
            case (m_mode[p])
                2'd1: hit = m && !rn;
                2'd2: hit = m && !wn;
                2'd3: hit = m && (!rn || !wn);
                default: hit = 1'b0;
            endcase
            if (m_mode[p] == 2'd0) begin
                o[p] = m_latch[p]; e[p] = ~m_latch[p];
            end else begin
                o[p] = ~hit; e[p] = 1'b1;
            end
        end
        return {e, o};
    endfunction

    task automatic pin_chk(input string tag);
        logic [7:0] ex;
        ex = expect_pins(bus_addr, bus_rd_n, bus_wr_n);
        check({pin_oe, pin_out} == ex, tag, {8'h0, pin_oe, pin_out}, {8'h0, ex});
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < 4; p++) begin
            m_base[p] = '0; m_mode[p] = '0; m_span[p] = '0;
        end
        m_latch = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of registers and pins.
        for (int a = 0; a < 10; a++) rd_chk(4'(a), 8'h00, "R1 reset register");
        rd_chk(4'd11, 8'h0F, "R1 reset latch");
        check(pin_out == 4'hF && pin_oe == 4'h0, "R1 reset pins", {8'h0, pin_oe, pin_out}, 16'h00F0 >> 4);

        // R2: map, pin_in read, unmapped addresses.
        rd_chk(4'd10, 8'h0A, "R2 pin_in read");
        for (int a = 0; a < 8; a++) wr(4'(a), 8'(8'h31 * (a + 1)));
        for (int a = 0; a < 8; a++) rd_chk(4'(a), 8'(8'h31 * (a + 1)), "R2 base byte readback");
        for (int a = 12; a < 16; a++) wr(4'(a), 8'hFF);
        for (int a = 0; a < 8; a++) rd_chk(4'(a), 8'(8'h31 * (a + 1)), "R2 unmapped write ignored");
        rd_chk(4'd8, 8'h00, "R2 unmapped write ignored ctrl");
        rd_chk(4'd11, 8'h0F, "R2 unmapped write ignored latch");
        for (int a = 12; a < 16; a++) rd_chk(4'(a), 8'h00, "R2 unmapped reads zero");
        for (int p = 0; p < 4; p++) m_base[p] = {8'(8'h31 * (2*p + 2)), 8'(8'h31 * (2*p + 1))};

        // R3: mode 0 follows the latch, every pattern.
        for (int v = 0; v < 16; v++) begin
            wr(4'd10, 8'(v)); m_latch = 4'(v);
            rd_chk(4'd11, 8'(v), "R2 latch readback");
            pin_chk("R3 gpio pattern");
        end

        // R4 R5 R6 R7 R9: sweep all modes, windows, strobes, overlapping bases.
        for (int c = 0; c < 16; c++) begin
            logic [15:0] b0;
            b0 = {8'(c * 17 + 3), 8'hF8};
            wr(4'd10, 8'(c)); m_latch = 4'(c);
            for (int q = 0; q < 4; q++)
                set_pin(q, b0 + 16'(q * 3), 2'((c / 4 + q) % 4), 2'((c + q) % 4));
            for (int a = -4; a <= 20; a++) begin
                for (int s = 0; s < 4; s++) begin
                    @(negedge clk);
                    bus_addr = b0 + 16'(a);
                    {bus_rd_n, bus_wr_n} = 2'(s);
                    #0.5;
                    pin_chk("R4 R5 R6 R7 R9 sweep");
                end
            end
            bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        end

        // R8: strobe follows the bus inside one cycle.
        set_pin(0, 16'h4000, 2'd1, 2'd0);
        wr(4'd10, 8'h0F); m_latch = 4'hF;
        @(negedge clk);
        bus_addr = 16'h4000; bus_rd_n = 1'b0;
        #0.5; check(pin_out[0] == 1'b0, "R8 same-cycle assert", {15'h0, pin_out[0]}, 16'h0);
        bus_rd_n = 1'b1;
        #0.5; check(pin_out[0] == 1'b1, "R8 same-cycle release", {15'h0, pin_out[0]}, 16'h1);
        bus_rd_n = 1'b0;
        #0.5; bus_addr = 16'h4001;
        #0.3; check(pin_out[0] == 1'b1, "R8 address leaves window", {15'h0, pin_out[0]}, 16'h1);

        // R10: reconfiguration and live hit in the same cycle.
        @(negedge clk);
        bus_addr = 16'h4000; bus_rd_n = 1'b0;
        reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = {ctrl_byte(0)[7:4], 4'h0};
        #0.5; check(pin_out[0] == 1'b0 && pin_oe[0], "R10 old setting before edge", {14'h0, pin_oe[0], pin_out[0]}, 16'h2);
        @(posedge clk); #0.5;
        check(pin_out[0] == 1'b1 && !pin_oe[0], "R10 new setting after edge", {14'h0, pin_oe[0], pin_out[0]}, 16'h1);
        @(negedge clk);
        reg_we = 1'b0; bus_rd_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule